// File: doc/BRIEF.md
# NaN Operand Resolver for a binary64 Result Path

This unit sits between a binary64 arithmetic core and the result bus. Each cycle it inspects the two operand words, the core's invalid-operation flag with its fault kind, and a 3-bit policy select. When no NaN is involved it forwards the core's numeric result unchanged. When one operand is a NaN, it forwards that NaN in quiet form. When both operands are NaN, it resolves the output payload by the selected policy. When the core reports an invalid operation on non-NaN operands, it generates a quiet NaN whose payload is either zero or a fault-kind tag.

The outcome and an invalid status bit are registered once, so they appear one clock after the inputs. The arithmetic itself stays in the core. This block only classifies the operands, generates NaNs and merges payloads.

A NaN has an all-ones exponent (bits 62:52) and a nonzero mantissa. Bit 51 is the quiet bit, and bits 50:0 are the payload. A signalling NaN has bit 51 clear and a nonzero payload.

Top module: `nan_resolve_unit`

## Requirements
- R1: With no NaN operand and `inv_i` low, `res_o` equals `core_res_i` from the previous cycle. After reset, `res_o` is 0 and `invalid_o` is 0.
- R2: With exactly one NaN operand, `res_o` is that operand with bit 51 forced to 1. Its sign and bits 50:0 are unchanged.
- R3: `invalid_o` is high exactly when either operand is a signalling NaN or `inv_i` is high. A quiet NaN operand alone leaves it low.
- R4: With `inv_i` high, no NaN operand and `tag_en_i` low, `res_o` is 64'h7FF8_0000_0000_0000.
- R5: With `inv_i` high, no NaN operand and `tag_en_i` high, the payload is `inv_kind_i`+1, so every kind gets a distinct nonzero code. Kind 0 means "no meaningful result" (0/0). Kind 1 means "valid only in complex numbers" (root of a negative). Kind 2 is INF-INF, and kind 3 is 0*INF. Sign is 0 and bit 51 is 1.
- R6: With two NaN operands and policy 0 (fixed), the result is sign 0, bit 51 set and payload `FIXED_PL`. The unused code 7 behaves the same.
- R7: With two NaN operands, policy 1 returns operand A and policy 2 returns operand B, each quieted.
- R8: With two NaN operands and policy 3, the result is A if both are quiet. Otherwise it is the signalling one, with A chosen if both are signalling. The result is always quieted.
- R9: With two NaN operands and policy 4, the payload is the bitwise OR of both payloads, and the sign is A's.
- R10: With two NaN operands, policy 5 returns the quieted operand with the larger payload and policy 6 the one with the smaller payload. On equal payloads both return A, so swapping operands with distinct payloads gives the same word.
- R11: Whenever an operand is NaN, the result follows R2/R6–R10 even if `inv_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 64 | First operand word |
| op_b_i | input | 64 | Second operand word |
| inv_i | input | 1 | Core flags an invalid operation |
| inv_kind_i | input | 2 | Kind of invalid operation |
| tag_en_i | input | 1 | Enables fault-kind payload tagging |
| policy_i | input | 3 | Two-NaN payload policy |
| core_res_i | input | 64 | Numeric result from the core |
| res_o | output | 64 | Final result word (registered) |
| invalid_o | output | 1 | Invalid status (registered) |

## Verification
The bench builds the unit with the default 2-bit kind field and a nonzero `FIXED_PL` of 51'h5A5. A nonzero fixed payload lets the fixed policy be told apart from any zero-payload path, including invalid generation with tagging off. The 2-bit kind field allows all four fault codes to be driven and compared for distinctness. Operand pairs are chosen with distinct signs and payloads, so every policy and every tie or swap case selects an observably different word.

// File: rtl/nan_pkg.sv
package nan_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int PL_W   = FRAC_W - 1;
  localparam int QBIT   = PL_W;

  typedef enum logic [2:0] {
    POL_FIXED  = 3'd0,
    POL_FIRST  = 3'd1,
    POL_SECOND = 3'd2,
    POL_SIGPRE = 3'd3,
    POL_OR     = 3'd4,
    POL_HIGH   = 3'd5,
    POL_LOW    = 3'd6,
    POL_RSVD   = 3'd7
  } policy_e;

  typedef struct packed {
    logic            is_nan;
    logic            is_snan;
    logic            sign;
    logic [PL_W-1:0] pl;
  } opnd_info_t;

  function automatic logic [FP_W-1:0] quieten(input logic [FP_W-1:0] w);
    logic [FP_W-1:0] r;
    r = w;
    r[QBIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [FP_W-1:0] mk_qnan(input logic s, input logic [PL_W-1:0] pl);
    return {s, {EXP_W{1'b1}}, 1'b1, pl};
  endfunction
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_pkg::*;
(
  input  logic [FP_W-1:0] word_i,
  output opnd_info_t      info_o
);
  logic exp_ones, frac_nz;

  assign exp_ones = &word_i[FP_W-2 -: EXP_W];
  assign frac_nz  = |word_i[FRAC_W-1:0];

  always_comb begin
    info_o.is_nan  = exp_ones & frac_nz;
    info_o.is_snan = exp_ones & frac_nz & ~word_i[QBIT];
    info_o.sign    = word_i[FP_W-1];
    info_o.pl      = word_i[PL_W-1:0];
  end
endmodule

// File: rtl/nan_pair_pick.sv
module nan_pair_pick
  import nan_pkg::*;
#(
  parameter logic [PL_W-1:0] FIXED_PL = '0
) (
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  opnd_info_t      ia_i,
  input  opnd_info_t      ib_i,
  input  logic [2:0]      policy_i,
  output logic [FP_W-1:0] res_o
);
  logic [FP_W-1:0] qa, qb;
  logic            a_ge_b, a_le_b;

  assign qa     = quieten(a_i);
  assign qb     = quieten(b_i);
  assign a_ge_b = ia_i.pl >= ib_i.pl;
  assign a_le_b = ia_i.pl <= ib_i.pl;

  always_comb begin
    unique case (policy_e'(policy_i))
      POL_FIRST:  res_o = qa;
      POL_SECOND: res_o = qb;
      POL_SIGPRE: begin
        if (ia_i.is_snan || !ib_i.is_snan) res_o = qa;
        else                               res_o = qb;
      end
      POL_OR:     res_o = mk_qnan(ia_i.sign, ia_i.pl | ib_i.pl);
      POL_HIGH:   res_o = a_ge_b ? qa : qb;
      POL_LOW:    res_o = a_le_b ? qa : qb;
      default:    res_o = mk_qnan(1'b0, FIXED_PL);
    endcase
  end
endmodule

// File: rtl/nan_gen.sv
module nan_gen
  import nan_pkg::*;
#(
  parameter int KIND_W = 2
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic              tag_en_i,
  output logic [FP_W-1:0]   res_o
);
  logic [PL_W-1:0] code;

  // kind k maps to code k+1 so that every tag is nonzero
  assign code  = PL_W'(kind_i) + PL_W'(1);
  assign res_o = mk_qnan(1'b0, tag_en_i ? code : '0);
endmodule

// File: rtl/nan_resolve_unit.sv
module nan_resolve_unit
  import nan_pkg::*;
#(
  parameter int              KIND_W   = 2,
  parameter logic [PL_W-1:0] FIXED_PL = 51'h5A5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FP_W-1:0]   op_a_i,
  input  logic [FP_W-1:0]   op_b_i,
  input  logic              inv_i,
  input  logic [KIND_W-1:0] inv_kind_i,
  input  logic              tag_en_i,
  input  logic [2:0]        policy_i,
  input  logic [FP_W-1:0]   core_res_i,
  output logic [FP_W-1:0]   res_o,
  output logic              invalid_o
);
  localparam int NOPS = 2;

  logic [FP_W-1:0] ops [NOPS];
  opnd_info_t      info [NOPS];
  logic [FP_W-1:0] pair_res, gen_res, res_d;
  logic            invalid_d;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    nan_classify u_cls (
      .word_i (ops[g]),
      .info_o (info[g])
    );
  end

  nan_pair_pick #(.FIXED_PL(FIXED_PL)) u_pick (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .ia_i     (info[0]),
    .ib_i     (info[1]),
    .policy_i (policy_i),
    .res_o    (pair_res)
  );

  nan_gen #(.KIND_W(KIND_W)) u_gen (
    .kind_i   (inv_kind_i),
    .tag_en_i (tag_en_i),
    .res_o    (gen_res)
  );

  always_comb begin
    if (info[0].is_nan && info[1].is_nan) res_d = pair_res;
    else if (info[0].is_nan)              res_d = quieten(op_a_i);
    else if (info[1].is_nan)              res_d = quieten(op_b_i);
    else if (inv_i)                       res_d = gen_res;
    else                                  res_d = core_res_i;
  end

  assign invalid_d = info[0].is_snan | info[1].is_snan | inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= invalid_d;
    end
  end
endmodule

// File: rtl/nan_resolve_chk.sv
module nan_resolve_chk
  import nan_pkg::*;
#(
  parameter int KIND_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FP_W-1:0]   op_a_i,
  input logic [FP_W-1:0]   op_b_i,
  input logic              inv_i,
  input logic [KIND_W-1:0] inv_kind_i,
  input logic              tag_en_i,
  input logic [2:0]        policy_i,
  input logic [FP_W-1:0]   core_res_i,
  input logic [FP_W-1:0]   res_o,
  input logic              invalid_o
);
  function automatic logic nan_w(input logic [FP_W-1:0] w);
    return (&w[FP_W-2 -: EXP_W]) && (|w[FRAC_W-1:0]);
  endfunction
  function automatic logic snan_w(input logic [FP_W-1:0] w);
    return nan_w(w) && !w[QBIT];
  endfunction

  logic started;
  logic na, nb, sa, sb;

  assign na = nan_w(op_a_i);
  assign nb = nan_w(op_b_i);
  assign sa = snan_w(op_a_i);
  assign sb = snan_w(op_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(!na && !nb && !inv_i) |-> res_o == $past(core_res_i)); // R1

  AST_SINGLE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(na && !nb) |-> res_o == ($past(op_a_i) | (64'd1 << QBIT))); // R2

  AST_OUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(na || nb) |-> nan_w(res_o) && res_o[QBIT]); // R11

  AST_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> invalid_o == $past(sa || sb || inv_i)); // R3

  AST_GEN_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(inv_i && !na && !nb && !tag_en_i) |-> res_o == 64'h7FF8_0000_0000_0000); // R4

  AST_TAG_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(inv_i && !na && !nb && tag_en_i) |-> res_o[PL_W-1:0] != '0); // R5

  AST_FIRST_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(na && nb && policy_i == 3'd1) |-> res_o == ($past(op_a_i) | (64'd1 << QBIT))); // R7

  AST_HIGH_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && $past(na && nb && policy_i == 3'd5) |->
      res_o[PL_W-1:0] >= $past(op_a_i[PL_W-1:0]) && res_o[PL_W-1:0] >= $past(op_b_i[PL_W-1:0])); // R10
endmodule

bind nan_resolve_unit nan_resolve_chk #(.KIND_W(KIND_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .inv_i      (inv_i),
  .inv_kind_i (inv_kind_i),
  .tag_en_i   (tag_en_i),
  .policy_i   (policy_i),
  .core_res_i (core_res_i),
  .res_o      (res_o),
  .invalid_o  (invalid_o)
);

// File: tb/nan_resolve_unit_bench.sv
module nan_resolve_unit_bench;
  localparam logic [50:0] FPL = 51'h5A5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] op_a_i = '0, op_b_i = '0, core_res_i = '0;
  logic        inv_i = 1'b0, tag_en_i = 1'b0;
  logic [1:0]  inv_kind_i = '0;
  logic [2:0]  policy_i = '0;
  logic [63:0] res_o;
  logic        invalid_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  nan_resolve_unit #(.KIND_W(2), .FIXED_PL(FPL)) u_nan_resolve_unit (.*);

  function automatic logic [63:0] qn(input logic s, input logic [50:0] pl);
    return {s, 11'h7FF, 1'b1, pl};
  endfunction
  function automatic logic [63:0] sn(input logic s, input logic [50:0] pl);
    return {s, 11'h7FF, 1'b0, pl};
  endfunction

  task automatic chk(input string req, input logic [63:0] er, input logic ei);
    checks++;
    if (res_o !== er || invalid_o !== ei) begin
      errors++;
      $display("FAIL %s res=%h inv=%b exp res=%h inv=%b", req, res_o, invalid_o, er, ei);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic inv,
                       input logic [1:0] k, input logic tag, input logic [2:0] pol,
                       input logic [63:0] core);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; inv_i = inv; inv_kind_i = k;
    tag_en_i = tag; policy_i = pol; core_res_i = core;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 reset", 64'h0, 1'b0);
  endtask

  task automatic t_pass();
    apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 0, 0, 3'd4, 64'h4008_0000_0000_0000);
    chk("R1 numeric", 64'h4008_0000_0000_0000, 1'b0);
    apply(64'h7FF0_0000_0000_0000, 64'h0, 0, 0, 1, 3'd0, 64'h7FF0_0000_0000_0000);
    chk("R1 infinity", 64'h7FF0_0000_0000_0000, 1'b0);
  endtask

  task automatic t_single();
    apply(qn(1, 51'h123), 64'h3FF0_0000_0000_0000, 0, 0, 0, 3'd0, 64'h1);
    chk("R2 qnan A", qn(1, 51'h123), 1'b0);
    apply(64'h1, qn(0, 51'h77), 0, 0, 0, 3'd5, 64'h2);
    chk("R2 qnan B", qn(0, 51'h77), 1'b0);
    apply(sn(1, 51'h9), 64'h0, 0, 0, 0, 3'd1, 64'h3);
    chk("R3 R2 snan quieted", qn(1, 51'h9), 1'b1);
  endtask

  task automatic t_invalid();
    apply(64'h0, 64'h0, 1, 2'd0, 0, 3'd0, 64'hDEAD);
    chk("R4 untagged", 64'h7FF8_0000_0000_0000, 1'b1);
    for (int k = 0; k < 4; k++) begin
      apply(64'h0, 64'h0, 1, k[1:0], 1, 3'd0, 64'hBEEF);
      chk("R5 tag kind", qn(0, 51'(k + 1)), 1'b1);
    end
    apply(qn(0, 51'h44), 64'h0, 1, 2'd2, 1, 3'd0, 64'h0);
    chk("R11 nan beats inv", qn(0, 51'h44), 1'b1);
  endtask

  task automatic t_policies();
    logic [63:0] a, b;
    a = qn(1, 51'h30); b = qn(0, 51'h0C);
    apply(a, b, 0, 0, 0, 3'd0, 0); chk("R6 fixed", qn(0, FPL), 1'b0);
    apply(a, b, 0, 0, 0, 3'd7, 0); chk("R6 code7", qn(0, FPL), 1'b0);
    apply(a, b, 0, 0, 0, 3'd1, 0); chk("R7 first", a, 1'b0);
    apply(a, b, 0, 0, 0, 3'd2, 0); chk("R7 second", b, 1'b0);
    apply(a, b, 0, 0, 0, 3'd3, 0); chk("R8 both quiet", a, 1'b0);
    apply(a, sn(0, 51'h0C), 0, 0, 0, 3'd3, 0); chk("R8 B signalling", b, 1'b1);
    apply(sn(1, 51'h30), sn(0, 51'h0C), 0, 0, 0, 3'd3, 0); chk("R8 both signalling", a, 1'b1);
    apply(a, b, 0, 0, 0, 3'd4, 0); chk("R9 or", qn(1, 51'h3C), 1'b0);
    apply(b, a, 0, 0, 0, 3'd4, 0); chk("R9 or swapped", qn(0, 51'h3C), 1'b0);
    apply(a, b, 0, 0, 0, 3'd5, 0); chk("R10 high", a, 1'b0);
    apply(b, a, 0, 0, 0, 3'd5, 0); chk("R10 high swapped", a, 1'b0);
    apply(a, b, 0, 0, 0, 3'd6, 0); chk("R10 low", b, 1'b0);
    apply(b, a, 0, 0, 0, 3'd6, 0); chk("R10 low swapped", b, 1'b0);
    apply(qn(1, 51'h21), qn(0, 51'h21), 0, 0, 0, 3'd5, 0); chk("R10 high tie", qn(1, 51'h21), 1'b0);
    apply(qn(0, 51'h21), qn(1, 51'h21), 0, 0, 0, 3'd6, 0); chk("R10 low tie", qn(0, 51'h21), 1'b0);
    apply(a, b, 1, 2'd1, 1, 3'd2, 0); chk("R11 pair beats inv", b, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_pass();
    t_single();
    t_invalid();
    t_policies();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule